// File: doc/BRIEF.md
# Power-on reset and clock-enable sequencer

This block owns the reset and clock-gating state of a display-controller chip from the moment its supplies come up until normal operation. An external power-sense level holds the whole chip in reset. Once the level rises, the PLL is let out of reset at once. The processor domain is released only after a fixed settling delay, which gives the PLL time to lock. Every other peripheral domain stays gated and in reset until software running on the processor writes a release for it.

A watchdog timeout puts the same defaults back without a power cycle, and the staged release then starts again. An early power-fail warning (power-good falling) raises a mirror-park request. The request is sticky until the next system reset. While the processor domain is in reset, an output-disable control keeps the chip's pins tri-stated or low. All three monitor inputs are asynchronous and each one is synchronised with two flops.

The software write port is a plain address/data/strobe port. It has no back-pressure: every strobe is taken in the cycle it is seen.

Top module: `pwr_seq_top`

## Requirements
- R1: While `pwr_sense_a` is low, the outputs take these values at once, without waiting for a clock edge:
  - `pll_rst_n` = 0
  - `cpu_rst_n` = 0
  - `cpu_clk_en` = 0
  - `dom_clk_en` = 0 and `dom_rst_n` = 0
  - `out_disable` = 1
  - `park_req` = 0
- R2: After `pwr_sense_a` rises, `pll_rst_n` goes high on the third rising clock edge. This counts two synchroniser edges and one state edge.
- R3: `cpu_rst_n` and `cpu_clk_en` go high exactly SETTLE_CYC clock cycles after `pll_rst_n` goes high. SETTLE_CYC = (CLK_HZ/1e6)·SETTLE_US.
- R4: `out_disable` stays 1 for as long as `cpu_rst_n` is 0, and it is 0 while the processor domain runs.
- R5: After every power-up or watchdog restart, all bits of `dom_clk_en` and `dom_rst_n` are 0. They stay 0 until software writes them.
- R6: With the processor domain running, a strobe (`wr_en`=1) with `wr_addr`=0 loads `wr_data` into `dom_clk_en`, and with `wr_addr`=1 loads it into `dom_rst_n`. Bit i of the data belongs to domain i. The new value appears after the clock edge that takes the strobe. Strobes to addresses 2 and 3 change nothing.
- R7: Strobes made while `cpu_rst_n` is 0 are ignored.
- R8: A synchronised watchdog high gives system reset. On the third edge after `wdog_a` rises, these outputs take the R1 reset values: `pll_rst_n`, `cpu_rst_n`, `cpu_clk_en`, the domain outputs and `out_disable`. The value of `park_req` during this reset is covered by R10. When `wdog_a` falls, the R2 and R3 timing repeats.
- R9: Once power-good has been seen high, a fall of `pwr_good_a` raises `park_req` on the second clock edge after the fall, unless system reset is active.
- R10: `park_req` stays high when power-good returns high. It is cleared only by system reset. If power-good is still low when a watchdog reset ends, `park_req` rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| pwr_sense_a | input | 1 | Asynchronous power-sense level, low holds reset |
| pwr_good_a | input | 1 | Asynchronous power-good, falling edge is an early power-fail warning |
| wdog_a | input | 1 | Asynchronous watchdog timeout, high requests system reset |
| wr_en | input | 1 | Software write strobe |
| wr_addr | input | ADDR_W | Write address: 0 clock enables, 1 reset releases |
| wr_data | input | N_DOM | Write data, one bit per domain |
| pll_rst_n | output | 1 | PLL reset, active low |
| cpu_rst_n | output | 1 | Processor-domain reset, active low |
| cpu_clk_en | output | 1 | Processor clock enable |
| dom_clk_en | output | N_DOM | Per-domain clock enables |
| dom_rst_n | output | N_DOM | Per-domain resets, active low |
| out_disable | output | 1 | Forces chip outputs to tri-state or low |
| park_req | output | 1 | Sticky mirror-park request |

## Verification
Two functions can meet in the same cycle: a watchdog reset and a power-good fall. The bench makes them meet by driving `wdog_a` high and `pwr_good_a` low on the same clock. It then checks three things. During the reset, `park_req` is held low and the domains are cleared. Two edges after the watchdog ends, `park_req` has risen again, so the warning is not lost. The request then stays set.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [1:0] {
    ST_HOLD   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_RUN    = 2'd2
  } seq_state_t;

  localparam int unsigned ADDR_CLK_EN  = 0;
  localparam int unsigned ADDR_RST_REL = 1;
endpackage

// File: rtl/pwr_seq_sync.sv
module pwr_seq_sync #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_seq_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 20
) (
  input  logic clk,
  input  logic arst_n,
  input  logic hold_i,
  output logic pll_rst_n,
  output logic run_o
);
  localparam int unsigned CNT_W = $clog2(SETTLE_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYC - 1);

  seq_state_t state_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state_q <= ST_HOLD;
      cnt_q   <= '0;
    end else if (hold_i) begin
      state_q <= ST_HOLD;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_HOLD: begin
          state_q <= ST_SETTLE;
          cnt_q   <= '0;
        end
        ST_SETTLE: begin
          if (cnt_q == CNT_LAST) state_q <= ST_RUN;
          else                   cnt_q   <= cnt_q + 1'b1;
        end
        default: state_q <= ST_RUN;
      endcase
    end
  end

  assign pll_rst_n = (state_q != ST_HOLD);
  assign run_o     = (state_q == ST_RUN);

  // R3: the settling counter never passes its terminal count
  p_settle_bound_r3: assert property (@(posedge clk) disable iff (!arst_n)
    (state_q == ST_SETTLE) |-> (cnt_q <= CNT_LAST));

  // R8: a system reset request always lands the sequencer in hold
  p_hold_on_reset_r8: assert property (@(posedge clk) disable iff (!arst_n)
    hold_i |=> (!pll_rst_n && !run_o));
endmodule

// File: rtl/pwr_seq_domregs.sv
module pwr_seq_domregs
  import pwr_seq_pkg::*;
#(
  parameter int unsigned N_DOM  = 4,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              hold_i,
  input  logic              run_i,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [N_DOM-1:0]  wr_data,
  output logic [N_DOM-1:0]  clk_en_o,
  output logic [N_DOM-1:0]  rst_rel_o
);
  logic [N_DOM-1:0] ce_q, rr_q;
  logic wr_ok;

  assign wr_ok = wr_en && run_i && !hold_i;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      ce_q <= '0;
      rr_q <= '0;
    end else if (hold_i || !run_i) begin
      ce_q <= '0;
      rr_q <= '0;
    end else if (wr_ok) begin
      if (wr_addr == ADDR_W'(ADDR_CLK_EN))  ce_q <= wr_data;
      if (wr_addr == ADDR_W'(ADDR_RST_REL)) rr_q <= wr_data;
    end
  end

  assign clk_en_o  = ce_q;
  assign rst_rel_o = rr_q;

  // R5: no peripheral domain is enabled or released unless the processor runs
  p_dom_gated_r5: assert property (@(posedge clk) disable iff (!arst_n)
    ((|ce_q) || (|rr_q)) |-> run_i);

  // R7: with the processor in reset, the domain registers do not take writes
  p_wr_ignored_r7: assert property (@(posedge clk) disable iff (!arst_n)
    !run_i |=> ((ce_q == '0) && (rr_q == '0)));
endmodule

// File: rtl/pwr_seq_park.sv
module pwr_seq_park (
  input  logic clk,
  input  logic arst_n,
  input  logic clr_i,
  input  logic pg_s,
  output logic park_req
);
  logic armed_q, park_q, fall_now;

  assign fall_now = armed_q && !pg_s && !clr_i;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      armed_q <= 1'b0;
      park_q  <= 1'b0;
    end else begin
      if (pg_s) armed_q <= 1'b1;
      if (clr_i)         park_q <= 1'b0;
      else if (fall_now) park_q <= 1'b1;
    end
  end

  assign park_req = park_q || fall_now;

  // R9: a synchronised power-good fall outside reset raises the request at once
  p_park_fast_r9: assert property (@(posedge clk) disable iff (!arst_n)
    ($fell(pg_s) && !clr_i) |-> park_req);

  // R10: the request is kept until a system reset
  p_park_sticky_r10: assert property (@(posedge clk) disable iff (!arst_n)
    (park_q && !clr_i) |=> park_q);
endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top #(
  parameter int unsigned CLK_HZ    = 50_000_000,
  parameter int unsigned SETTLE_US = 100_000,
  parameter int unsigned N_DOM     = 4,
  parameter int unsigned ADDR_W    = 2
) (
  input  logic              clk_ref,
  input  logic              pwr_sense_a,
  input  logic              pwr_good_a,
  input  logic              wdog_a,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [N_DOM-1:0]  wr_data,
  output logic              pll_rst_n,
  output logic              cpu_rst_n,
  output logic              cpu_clk_en,
  output logic [N_DOM-1:0]  dom_clk_en,
  output logic [N_DOM-1:0]  dom_rst_n,
  output logic              out_disable,
  output logic              park_req
);
  localparam int unsigned SETTLE_CYC = (CLK_HZ / 1_000_000) * SETTLE_US;

  logic sense_s, wdog_s, pg_s, sys_hold, run;

  pwr_seq_sync #(.RST_VAL(1'b0)) u_sync_sense (
    .clk(clk_ref), .arst_n(pwr_sense_a), .d(1'b1), .q(sense_s));
  pwr_seq_sync #(.RST_VAL(1'b0)) u_sync_wdog (
    .clk(clk_ref), .arst_n(pwr_sense_a), .d(wdog_a), .q(wdog_s));
  pwr_seq_sync #(.RST_VAL(1'b0)) u_sync_pg (
    .clk(clk_ref), .arst_n(pwr_sense_a), .d(pwr_good_a), .q(pg_s));

  assign sys_hold = !sense_s || wdog_s;

  pwr_seq_fsm #(.SETTLE_CYC(SETTLE_CYC)) u_fsm (
    .clk(clk_ref), .arst_n(pwr_sense_a), .hold_i(sys_hold),
    .pll_rst_n(pll_rst_n), .run_o(run));

  pwr_seq_domregs #(.N_DOM(N_DOM), .ADDR_W(ADDR_W)) u_dom (
    .clk(clk_ref), .arst_n(pwr_sense_a), .hold_i(sys_hold), .run_i(run),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .clk_en_o(dom_clk_en), .rst_rel_o(dom_rst_n));

  pwr_seq_park u_park (
    .clk(clk_ref), .arst_n(pwr_sense_a), .clr_i(sys_hold),
    .pg_s(pg_s), .park_req(park_req));

  assign cpu_rst_n   = run;
  assign cpu_clk_en  = run;
  assign out_disable = !run;

  // R4: outputs are released only while the PLL is out of reset
  p_outdis_pll_r4: assert property (@(posedge clk_ref) disable iff (!pwr_sense_a)
    !pll_rst_n |-> out_disable);
endmodule

// File: tb/test_pwr_seq_top.sv
module test_pwr_seq_top;
  localparam int N_DOM = 4;
  localparam int SETTLE = 20;

  logic clk = 1'b0;
  logic pwr_sense_a = 1'b0, pwr_good_a = 1'b0, wdog_a = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [N_DOM-1:0] wr_data = '0;
  logic pll_rst_n, cpu_rst_n, cpu_clk_en, out_disable, park_req;
  logic [N_DOM-1:0] dom_clk_en, dom_rst_n;

  int n_chk = 0, n_err = 0;
  logic [N_DOM-1:0] ce_m, rr_m;

  always #10 clk = ~clk;

  pwr_seq_top #(.CLK_HZ(1_000_000), .SETTLE_US(SETTLE), .N_DOM(N_DOM), .ADDR_W(2)) i_pwr_seq_top (
    .clk_ref(clk), .pwr_sense_a(pwr_sense_a), .pwr_good_a(pwr_good_a), .wdog_a(wdog_a),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pll_rst_n(pll_rst_n), .cpu_rst_n(cpu_rst_n), .cpu_clk_en(cpu_clk_en),
    .dom_clk_en(dom_clk_en), .dom_rst_n(dom_rst_n),
    .out_disable(out_disable), .park_req(park_req));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [N_DOM-1:0] model_reg(input logic [N_DOM-1:0] cur,
      input logic [1:0] a, input logic [1:0] tgt, input logic [N_DOM-1:0] d);
    return (a == tgt) ? d : cur;
  endfunction

  task automatic write(input logic [1:0] a, input logic [N_DOM-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick(1);
    wr_en = 1'b0;
  endtask

  task automatic check_reset_state(input string req);
    check({req, " pll_rst_n"}, pll_rst_n, 0);
    check({req, " cpu_rst_n"}, cpu_rst_n, 0);
    check({req, " cpu_clk_en"}, cpu_clk_en, 0);
    check({req, " dom_clk_en"}, dom_clk_en, 0);
    check({req, " dom_rst_n"}, dom_rst_n, 0);
    check({req, " out_disable"}, out_disable, 1);
  endtask

  task automatic staged_release(input string req);
    int n;
    logic od_ok;
    n = 0;
    while (!pll_rst_n && n < 100) begin tick(1); n++; end
    check({req, " R2 cycles to pll release"}, n, 3);
    n = 0; od_ok = 1'b1;
    while (!cpu_rst_n && n < 100) begin
      if (!out_disable) od_ok = 1'b0;
      tick(1); n++;
    end
    check({req, " R3 settle cycles"}, n, SETTLE);
    check({req, " R3 cpu_clk_en"}, cpu_clk_en, 1);
    check({req, " R4 out_disable held during settle"}, od_ok, 1);
    check({req, " R4 out_disable released"}, out_disable, 0);
    check({req, " R5 dom_clk_en default"}, dom_clk_en, 0);
    check({req, " R5 dom_rst_n default"}, dom_rst_n, 0);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    tick(3);
    check_reset_state("R1");
    check("R1 park_req", park_req, 0);

    // R7: writes in reset are ignored
    write(2'd0, '1);
    write(2'd1, '1);
    check("R7 clk_en after write in reset", dom_clk_en, 0);
    check("R7 rst_n after write in reset", dom_rst_n, 0);

    pwr_sense_a = 1'b1; pwr_good_a = 1'b1;
    staged_release("power-up");

    // R6: random writes including ignored addresses
    ce_m = '0; rr_m = '0;
    for (int i = 0; i < 40; i++) begin
      logic [1:0] a;
      logic [N_DOM-1:0] d;
      a = 2'($urandom % 4);
      d = N_DOM'($urandom);
      write(a, d);
      ce_m = model_reg(ce_m, a, 2'd0, d);
      rr_m = model_reg(rr_m, a, 2'd1, d);
      check("R6 dom_clk_en", dom_clk_en, ce_m);
      check("R6 dom_rst_n", dom_rst_n, rr_m);
    end
    // R6 directed: address 3 leaves both untouched
    write(2'd3, ~ce_m);
    check("R6 addr3 ignored clk_en", dom_clk_en, ce_m);
    check("R6 addr3 ignored rst_n", dom_rst_n, rr_m);

    // R9: park request after power-good fall
    pwr_good_a = 1'b0;
    tick(1);
    check("R9 park_req one edge after fall", park_req, 0);
    tick(1);
    check("R9 park_req two edges after fall", park_req, 1);
    pwr_good_a = 1'b1;
    tick(5);
    check("R10 park_req sticky", park_req, 1);
    check("R10 cpu still running", cpu_rst_n, 1);

    // R8: watchdog reset restores defaults and restages
    write(2'd0, 4'hF);
    wdog_a = 1'b1;
    tick(2);
    check("R8 cpu still running two edges in", cpu_rst_n, 1);
    tick(1);
    check_reset_state("R8");
    check("R10 park cleared by watchdog", park_req, 0);
    tick(2);
    wdog_a = 1'b0;
    staged_release("R8 watchdog restart");
    check("R10 park stays clear after restart", park_req, 0);

    // Coincident watchdog and power-good fall
    write(2'd0, 4'hA);
    check("R6 write after restart", dom_clk_en, 4'hA);
    wdog_a = 1'b1; pwr_good_a = 1'b0;
    tick(3);
    check("R10 park masked in reset", park_req, 0);
    check("R8 domains cleared in coincident reset", dom_clk_en, 0);
    wdog_a = 1'b0;
    tick(2);
    check("R10 park re-raised after watchdog", park_req, 1);
    pwr_good_a = 1'b1;
    tick(4);
    check("R10 park kept after pg returns", park_req, 1);

    // R1: power-sense low acts at once
    @(negedge clk);
    pwr_sense_a = 1'b0;
    #1;
    check_reset_state("R1 async");
    check("R1 async park_req", park_req, 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(20 * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog timeout actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule